// File: doc/BRIEF.md
# Immediate-Amount Operand Shifter with Flag Register

This block shifts a 32-bit register operand by an amount carried as a 5-bit immediate inside an instruction word. It supports four shift kinds and produces the shifted value and a shifter carry bit in the same cycle. It extracts the amount and the kind from one of three instruction layouts: a full 32-bit word, an extended 32-bit word, and a 16-bit short word. An encoded amount of zero does not always mean "no shift". For a right shift, either logical or arithmetic, it means a shift by 32. For a rotate it means a one-bit rotate through the carry flag. The bit that becomes the carry depends on both the kind and the amount.

The block holds three flags: C, N and Z. They change only on a clock edge, and only when a flag update is permitted. For the two 32-bit layouts the update follows a request input. For the 16-bit layout it is permitted only outside a conditional-execution block. A datapath drives the operand and the instruction word and reads the result in the same cycle. The flags become visible after the next rising edge. The reset is asynchronous and active low. It clears the flags at once and is released through a two-stage synchronizer.

Top module: `immsh_unit`

## Requirements
- R1: Shift kind code 0 is logical left, 1 is logical right, 2 is arithmetic right and 3 is rotate right. A logical left shift by n in 1..31 yields the operand shifted left with zeros filled in, and its carry is operand bit 32-n.
- R2: A logical left shift with amount 0 returns the operand unchanged. Its carry output equals the current C flag, so an update leaves C as it was.
- R3: A logical right shift with encoded amount 0 acts as a shift by 32. The result is zero and the carry is operand bit 31.
- R4: A logical right shift by n in 1..31 fills zeros from the top, and its carry is operand bit n-1.
- R5: An arithmetic right shift by n in 1..31 fills copies of bit 31 from the top, with carry bit n-1. With encoded amount 0 every result bit equals operand bit 31, and the carry is bit 31.
- R6: A rotate right by n in 1..31 rotates the operand by n, and its carry is operand bit n-1.
- R7: A rotate with encoded amount 0 places the current C flag in bit 31 above operand bits 31:1, and its carry is operand bit 0.
- R8: In format code 0 (full word) the amount is instruction bits 11:7 and the kind is bits 6:5. Flags update when the request input is high.
- R9: In format code 1 (extended word) the amount is bits 14:12 as its top three bits above bits 7:6, and the kind is bits 5:4. Flags update when the request input is high.
- R10: In format code 2 (short word) the amount is bits 10:6 and the kind is bits 12:11. Flags update exactly when the conditional-block input is low, whatever the request input is.
- R11: Format code 3 decodes like format 0 but never updates the flags.
- R12: On a rising edge with update permitted, C takes the carry output, N takes result bit 31, and Z is set when the result is zero.
- R13: With update not permitted, the result and carry are still produced, and C, N and Z keep their values across the edge.
- R14: A low reset clears C, N and Z at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_sel | input | 2 | Instruction layout: 0 full, 1 extended, 2 short, 3 reserved |
| insn_word | input | 32 | Instruction word; the short layout uses bits 15:0 |
| opnd | input | 32 | Operand to be shifted |
| set_flags_req | input | 1 | Flag update request for the 32-bit layouts |
| in_cond_blk | input | 1 | High when a short instruction sits inside a conditional-execution block |
| sh_result | output | 32 | Shifted value (combinational) |
| sh_carry | output | 1 | Shifter carry (combinational) |
| flag_c | output | 1 | Registered carry flag |
| flag_n | output | 1 | Registered negative flag |
| flag_z | output | 1 | Registered zero flag |

## Verification
The only internal state is the flag register, and C feeds back into the datapath. A wrong C therefore shows up on the very next rotate-through-carry or zero-amount left shift: it appears in bit 31 or on the carry port in the same cycle as that instruction. A wrong N or Z shows on the flag ports one edge after the faulty update. A missed or extra update shows one edge after an instruction whose enable should have been the other way. The stimulus alternates the enable, the layout and the conditional-block input, so a bad enable decode is exposed within a few vectors.

// File: rtl/immsh_pkg.sv
package immsh_pkg;
  localparam int DW = 32;
  localparam int AW = $clog2(DW);
  localparam int IW = 32;

  typedef enum logic [1:0] {
    SK_LSL = 2'd0,
    SK_LSR = 2'd1,
    SK_ASR = 2'd2,
    SK_ROR = 2'd3
  } shk_e;

  typedef enum logic [1:0] {
    FMT_FULL  = 2'd0,
    FMT_EXT   = 2'd1,
    FMT_SHORT = 2'd2,
    FMT_RSVD  = 2'd3
  } fmt_e;
endpackage

// File: rtl/immsh_decode.sv
module immsh_decode
  import immsh_pkg::*;
(
  input  logic [1:0]    fmt_sel,
  input  logic [IW-1:0] insn_word,
  input  logic          set_flags_req,
  input  logic          in_cond_blk,
  output logic [AW-1:0] amt,
  output shk_e          kind,
  output logic          upd_en
);
  // field positions per layout
  localparam int FULL_AMT_LO = 7;
  localparam int FULL_KND_LO = 5;
  localparam int EXT_HI_LO   = 12;
  localparam int EXT_LO_LO   = 6;
  localparam int EXT_KND_LO  = 4;
  localparam int SH_AMT_LO   = 6;
  localparam int SH_KND_LO   = 11;
  localparam int EXT_HI_W    = 3;
  localparam int EXT_LO_W    = AW - EXT_HI_W;

  logic [AW-1:0] full_amt, ext_amt, short_amt;
  logic [1:0]    full_knd, ext_knd, short_knd;

  always_comb begin
    full_amt  = insn_word[FULL_AMT_LO +: AW];
    full_knd  = insn_word[FULL_KND_LO +: 2];
    ext_amt   = {insn_word[EXT_HI_LO +: EXT_HI_W], insn_word[EXT_LO_LO +: EXT_LO_W]};
    ext_knd   = insn_word[EXT_KND_LO +: 2];
    short_amt = insn_word[SH_AMT_LO +: AW];
    short_knd = insn_word[SH_KND_LO +: 2];
  end

  always_comb begin
    amt    = full_amt;
    kind   = shk_e'(full_knd);
    upd_en = 1'b0;
    unique case (fmt_e'(fmt_sel))
      FMT_FULL: begin
        amt    = full_amt;
        kind   = shk_e'(full_knd);
        upd_en = set_flags_req;
      end
      FMT_EXT: begin
        amt    = ext_amt;
        kind   = shk_e'(ext_knd);
        upd_en = set_flags_req;
      end
      FMT_SHORT: begin
        amt    = short_amt;
        kind   = shk_e'(short_knd);
        upd_en = ~in_cond_blk;
      end
      default: begin
        amt    = full_amt;
        kind   = shk_e'(full_knd);
        upd_en = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/immsh_core.sv
module immsh_core
  import immsh_pkg::*;
(
  input  logic [DW-1:0] opnd,
  input  logic [AW-1:0] amt,
  input  shk_e          kind,
  input  logic          cin,
  output logic [DW-1:0] result,
  output logic          cout
);
  localparam logic [DW-1:0] ONES = {DW{1'b1}};

  logic [AW-1:0] rot_amt;
  logic [AW-1:0] car_idx;
  logic          amt_zero;
  logic          sign_b;
  logic [DW-1:0] hi_mask;
  logic [DW-1:0] lo_mask;
  logic [DW-1:0] stg [0:AW];

  // left shift is a right rotate by (DW - n), i.e. the two's complement of n
  always_comb begin
    amt_zero = (amt == '0);
    sign_b   = opnd[DW-1];
    rot_amt  = (kind == SK_LSL) ? (~amt + 1'b1) : amt;
    car_idx  = (kind == SK_LSL) ? rot_amt : (amt - 1'b1);
    hi_mask  = ~(ONES >> amt);
    lo_mask  = ~(ONES << amt);
  end

  // logarithmic right rotator
  assign stg[0] = opnd;
  generate
    for (genvar k = 0; k < AW; k++) begin : g_rot
      localparam int SH = 1 << k;
      assign stg[k+1] = rot_amt[k] ? {stg[k][SH-1:0], stg[k][DW-1:SH]} : stg[k];
    end
  endgenerate

  always_comb begin
    result = stg[AW];
    cout   = opnd[car_idx];
    unique case (kind)
      SK_LSL: begin
        if (amt_zero) begin
          result = opnd;
          cout   = cin;
        end else begin
          result = stg[AW] & ~lo_mask;
        end
      end
      SK_LSR: begin
        if (amt_zero) begin
          result = '0;
          cout   = sign_b;
        end else begin
          result = stg[AW] & ~hi_mask;
        end
      end
      SK_ASR: begin
        if (amt_zero) begin
          result = {DW{sign_b}};
          cout   = sign_b;
        end else begin
          result = (stg[AW] & ~hi_mask) | (hi_mask & {DW{sign_b}});
        end
      end
      default: begin
        if (amt_zero) begin
          result = {cin, opnd[DW-1:1]};
          cout   = opnd[0];
        end else begin
          result = stg[AW];
        end
      end
    endcase
  end
endmodule

// File: rtl/immsh_flags.sv
module immsh_flags
  import immsh_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd_en,
  input  logic          cout,
  input  logic [DW-1:0] result,
  output logic          rst_core_n,
  output logic          flag_c,
  output logic          flag_n,
  output logic          flag_z
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rs_q;
  logic c_d, n_d, z_d;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_core_n = rs_q[SYNC_STAGES-1];

  always_comb begin
    c_d = cout;
    n_d = result[DW-1];
    z_d = (result == '0);
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      flag_c <= 1'b0;
      flag_n <= 1'b0;
      flag_z <= 1'b0;
    end else if (upd_en) begin
      flag_c <= c_d;
      flag_n <= n_d;
      flag_z <= z_d;
    end
  end
endmodule

// File: rtl/immsh_unit.sv
module immsh_unit
  import immsh_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    fmt_sel,
  input  logic [IW-1:0] insn_word,
  input  logic [DW-1:0] opnd,
  input  logic          set_flags_req,
  input  logic          in_cond_blk,
  output logic [DW-1:0] sh_result,
  output logic          sh_carry,
  output logic          flag_c,
  output logic          flag_n,
  output logic          flag_z
);
  logic [AW-1:0] sh_amt;
  shk_e          sh_kind;
  logic          upd_en;
  logic          rst_core_n;

  immsh_decode u_dec (
    .fmt_sel       (fmt_sel),
    .insn_word     (insn_word),
    .set_flags_req (set_flags_req),
    .in_cond_blk   (in_cond_blk),
    .amt           (sh_amt),
    .kind          (sh_kind),
    .upd_en        (upd_en)
  );

  immsh_core u_core (
    .opnd   (opnd),
    .amt    (sh_amt),
    .kind   (sh_kind),
    .cin    (flag_c),
    .result (sh_result),
    .cout   (sh_carry)
  );

  immsh_flags u_flg (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd_en     (upd_en),
    .cout       (sh_carry),
    .result     (sh_result),
    .rst_core_n (rst_core_n),
    .flag_c     (flag_c),
    .flag_n     (flag_n),
    .flag_z     (flag_z)
  );
endmodule

// File: rtl/immsh_chk.sv
module immsh_chk
  import immsh_pkg::*;
(
  input logic          clk,
  input logic          rst_core_n,
  input logic          upd_en,
  input logic [AW-1:0] sh_amt,
  input shk_e          sh_kind,
  input logic [DW-1:0] opnd,
  input logic [DW-1:0] sh_result,
  input logic          sh_carry,
  input logic          flag_c,
  input logic          flag_n,
  input logic          flag_z
);
  p_c_load_r12: assert property (@(posedge clk) disable iff (!rst_core_n)
    upd_en |=> flag_c == $past(sh_carry));

  p_nz_load_r12: assert property (@(posedge clk) disable iff (!rst_core_n)
    upd_en |=> (flag_n == $past(sh_result[DW-1])) && (flag_z == ($past(sh_result) == '0)));

  p_hold_r13: assert property (@(posedge clk) disable iff (!rst_core_n)
    !upd_en |=> $stable({flag_c, flag_n, flag_z}));

  p_lsl_zero_r2: assert property (@(posedge clk) disable iff (!rst_core_n)
    (sh_kind == SK_LSL && sh_amt == '0) |-> (sh_result == opnd && sh_carry == flag_c));

  p_lsr_full_r3: assert property (@(posedge clk) disable iff (!rst_core_n)
    (sh_kind == SK_LSR && sh_amt == '0) |-> (sh_result == '0 && sh_carry == opnd[DW-1]));

  p_asr_full_r5: assert property (@(posedge clk) disable iff (!rst_core_n)
    (sh_kind == SK_ASR && sh_amt == '0) |-> (sh_result == {DW{opnd[DW-1]}} && sh_carry == opnd[DW-1]));

  p_rrx_r7: assert property (@(posedge clk) disable iff (!rst_core_n)
    (sh_kind == SK_ROR && sh_amt == '0) |-> (sh_result == {flag_c, opnd[DW-1:1]} && sh_carry == opnd[0]));

  always @(negedge clk) begin
    if (!rst_core_n) begin
      p_reset_clear_r14: assert ({flag_c, flag_n, flag_z} == 3'b000);
    end
  end
endmodule

bind immsh_unit immsh_chk u_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .upd_en     (upd_en),
  .sh_amt     (sh_amt),
  .sh_kind    (sh_kind),
  .opnd       (opnd),
  .sh_result  (sh_result),
  .sh_carry   (sh_carry),
  .flag_c     (flag_c),
  .flag_n     (flag_n),
  .flag_z     (flag_z)
);

// File: tb/sim_immsh_unit.sv
module sim_immsh_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  fmt_sel;
  logic [31:0] insn_word;
  logic [31:0] opnd;
  logic        set_flags_req;
  logic        in_cond_blk;
  logic [31:0] sh_result;
  logic        sh_carry;
  logic        flag_c, flag_n, flag_z;

  int vec = 0;
  int bad = 0;
  bit m_c = 0, m_n = 0, m_z = 0;

  always #5 clk = ~clk;

  immsh_unit u0 (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .insn_word(insn_word),
    .opnd(opnd), .set_flags_req(set_flags_req), .in_cond_blk(in_cond_blk),
    .sh_result(sh_result), .sh_carry(sh_carry),
    .flag_c(flag_c), .flag_n(flag_n), .flag_z(flag_z)
  );

  // behavioural reference: returns {carry, result}
  function automatic logic [32:0] ref_sh(input logic [31:0] d, input int t, input int n, input bit c);
    logic [31:0] r;
    bit co;
    case (t)
      0: if (n == 0) begin r = d; co = c; end
         else begin r = d << n; co = d[32-n]; end
      1: if (n == 0) begin r = 0; co = d[31]; end
         else begin r = d >> n; co = d[n-1]; end
      2: if (n == 0) begin r = {32{d[31]}}; co = d[31]; end
         else begin r = 32'($signed(d) >>> n); co = d[n-1]; end
      default: if (n == 0) begin r = {c, d[31:1]}; co = d[0]; end
         else begin r = (d >> n) | (d << (32 - n)); co = d[n-1]; end
    endcase
    return {co, r};
  endfunction

  // place amount and kind into the layout, other bits filled with noise
  function automatic logic [31:0] build(input int f, input int n, input int t, input logic [31:0] fill);
    logic [31:0] a = 32'(n);
    logic [31:0] k = 32'(t);
    case (f)
      1: return (fill & ~32'h0000_70F0) | ((a >> 2) << 12) | ((a & 3) << 6) | (k << 4);
      2: return (fill & ~32'h0000_1FC0) | (a << 6) | (k << 11);
      default: return (fill & ~32'h0000_0FE0) | (a << 7) | (k << 5);
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input int f, input int t, input int n, input logic [31:0] d,
                       input bit req, input bit cnd, input logic [31:0] fill, input string tag);
    logic [32:0] e;
    bit en;
    @(negedge clk);
    fmt_sel = 2'(f);
    insn_word = build(f, n, t, fill);
    opnd = d;
    set_flags_req = req;
    in_cond_blk = cnd;
    #1;
    e = ref_sh(d, t, n, m_c);
    chk(sh_result == e[31:0], tag, "result", sh_result, e[31:0]);
    chk(sh_carry == e[32], tag, "carry", {31'b0, sh_carry}, {31'b0, e[32]});
    en = (f == 0 || f == 1) ? req : (f == 2) ? !cnd : 1'b0;
    if (en) begin m_c = e[32]; m_n = e[31]; m_z = (e[31:0] == 0); end
    @(posedge clk);
    #1;
    chk({flag_c, flag_n, flag_z} == {m_c, m_n, m_z}, tag, "flags CNZ",
        {29'b0, flag_c, flag_n, flag_z}, {29'b0, m_c, m_n, m_z});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    m_c = 0; m_n = 0; m_z = 0;
    chk({flag_c, flag_n, flag_z} == 3'b000, "R14", "flags async clear",
        {29'b0, flag_c, flag_n, flag_z}, 32'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    fmt_sel = 2'd0; insn_word = '0; opnd = '0; set_flags_req = 1'b0; in_cond_blk = 1'b1;
    repeat (3) @(negedge clk);
    chk({flag_c, flag_n, flag_z} == 3'b000, "R14", "flags in reset",
        {29'b0, flag_c, flag_n, flag_z}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 logical left, nonzero amounts
    apply(0, 0, 1,  32'h8000_0001, 1, 0, 32'hFFFF_FFFF, "R1");
    apply(0, 0, 31, 32'h0000_0003, 1, 0, 32'h1234_5678, "R1");
    apply(0, 0, 4,  32'h1000_0000, 1, 0, 32'h0,         "R1");
    // R2 left by zero keeps carry (set C first)
    apply(0, 1, 1,  32'h0000_0001, 1, 0, 32'h0,         "R4");
    apply(0, 0, 0,  32'h0000_0000, 1, 0, 32'hDEAD_BEEF, "R2");
    apply(0, 0, 0,  32'h7654_3210, 1, 0, 32'h0,         "R2");
    // R3 / R4
    apply(0, 1, 0,  32'h8000_0000, 1, 0, 32'h0,         "R3");
    apply(0, 1, 0,  32'h7FFF_FFFF, 1, 0, 32'h0,         "R3");
    apply(0, 1, 31, 32'hC000_0000, 1, 0, 32'h0,         "R4");
    // R5
    apply(0, 2, 0,  32'h8000_0000, 1, 0, 32'h0,         "R5");
    apply(0, 2, 0,  32'h7000_0000, 1, 0, 32'h0,         "R5");
    apply(0, 2, 8,  32'hF000_0080, 1, 0, 32'h0,         "R5");
    // R6 / R7
    apply(0, 3, 1,  32'h0000_0001, 1, 0, 32'h0,         "R6");
    apply(0, 3, 16, 32'h1234_8765, 1, 0, 32'h0,         "R6");
    apply(0, 3, 0,  32'h0000_0003, 1, 0, 32'h0,         "R7");
    apply(0, 3, 0,  32'h0000_0002, 1, 0, 32'h0,         "R7");
    // R8 R9 R10 R11 layouts with noise bits
    apply(0, 2, 13, 32'h8123_4567, 1, 0, 32'hFFFF_FFFF, "R8");
    apply(1, 1, 21, 32'hA5A5_0F0F, 1, 0, 32'hFFFF_FFFF, "R9");
    apply(1, 3, 6,  32'h0F0F_1234, 0, 0, 32'hFFFF_FFFF, "R9");
    apply(2, 2, 19, 32'h9000_0001, 0, 0, 32'hFFFF_FFFF, "R10");
    apply(2, 0, 3,  32'hFFFF_FFFF, 1, 1, 32'hFFFF_FFFF, "R10");
    apply(3, 1, 0,  32'h8000_0000, 1, 0, 32'hFFFF_FFFF, "R11");
    // R12 / R13 zero and negative results, then held
    apply(0, 1, 0,  32'h0000_0001, 1, 0, 32'h0,         "R12");
    apply(0, 0, 0,  32'h8000_0000, 1, 0, 32'h0,         "R12");
    apply(0, 1, 1,  32'h0000_0001, 0, 0, 32'h0,         "R13");

    for (int i = 0; i < 600; i++) begin
      int f = $urandom_range(3);
      int t = $urandom_range(3);
      int n = ($urandom_range(3) == 0) ? 0 : $urandom_range(31);
      string tag;
      tag = (f == 1) ? "R9" : (f == 2) ? "R10" : (f == 3) ? "R11" : "R12";
      apply(f, t, n, $urandom, $urandom_range(1), $urandom_range(1), $urandom, tag);
      if (i == 300) do_reset();
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule